// File: doc/BRIEF.md
# Block-Granular FIFO Service Flag Controller

This block holds the status, interrupt and error logic that sits beside the receive and transmit word FIFOs of a serial engine. It does not store data. It watches push and pop strobes and the current fill level of each FIFO. From these it raises service flags once per block of words rather than once per word. It also raises block-level request levels, marks when a programmed word count has been consumed, and latches overrun and underrun errors.

Block and FIFO depths are fixed at elaboration from one encoded size parameter. For each direction, a 2-bit block code selects 1 word when the code is 0, and 4·n words (16·n bytes) when the code is n. A 3-bit depth code d multiplies the block by (2 << d). Software reaches the block through a simple write port, and the status outputs are always visible. Flag registers are cleared by writing 1 to a bit. An interrupt line merges the errors, the done flags and the service flags; a mask register can silence either service flag.

The receive service flag is deliberately sticky at the end of a transfer. It is set again when the final word is drained, so the handler has to clear it a second time after it sees the done flag.

Top module: `fsf_service_flags`

## Requirements
- R1: With the default size parameter (10'h028), the receive block is 4 words, the receive FIFO is 8 words, the transmit block is 1 word and the transmit FIFO is 8 words. The encoding is: transmit block code at bits [1:0], transmit depth code at [4:2], receive block code at [6:5], receive depth code at [9:7].
- R2: Status levels are combinational from the levels. op_status[13] is high when rx_level >= receive block. op_status[12] is high when (transmit depth − tx_level) >= transmit block. op_status[7] and [6] mean receive or transmit full (level equals depth). op_status[5] and [4] mean receive or transmit not empty. Bits [3:0] read 0.
- R3: op_status[9] (receive service) sets in the cycle after every receive-block-th accepted rx_push. A push made while rx_level equals the receive depth is not accepted and is not counted.
- R4: op_status[8] (transmit service) sets in the cycle after every transmit-block-th accepted tx_pop. A pop made while tx_level is 0 is not counted.
- R5: Writing address 0 clears each of op_status[11:8] whose bit in reg_wdata is 1. A 0 bit leaves the flag unchanged. A set event in the same cycle wins over the clear.
- R6: Writing address 4 loads the receive target count, restarts the receive counters and clears op_status[11]. op_status[11] sets when the accepted rx_pop count reaches a non-zero target. A target of 0 never sets it.
- R7: Writing address 5 loads the transmit target count, restarts the transmit counters and clears op_status[10]. op_status[10] sets when the accepted tx_pop count reaches a non-zero target.
- R8: The accepted rx_pop that sets op_status[11] also sets op_status[9] again. That flag then stays set until it is cleared a second time.
- R9: err_flags bit 2 latches on rx_push while the receive FIFO is full, bit 4 on rx_pop while it is empty, bit 5 on tx_push while the transmit FIFO is full, and bit 3 on tx_pop while it is empty. Each bit latches only if the same bit is set in the enable register (address 2). Writing address 1 clears err_flags bits written as 1.
- R10: irq is the OR of any err_flags bit, op_status[11], op_status[10], op_status[9] unless mask bit 9 is set, and op_status[8] unless mask bit 8 is set. The mask register is at address 3, and masking does not hide the status bit.
- R11: After reset all flag registers, enables, masks and targets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Serial engine writes a word into the receive FIFO |
| rx_pop | input | 1 | Host reads a word from the receive FIFO |
| rx_level | input | LVL_W | Current receive FIFO fill in words |
| tx_push | input | 1 | Host writes a word into the transmit FIFO |
| tx_pop | input | 1 | Serial engine takes a word from the transmit FIFO |
| tx_level | input | LVL_W | Current transmit FIFO fill in words |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| op_status | output | 14 | Operational status and sticky flags |
| err_flags | output | 6 | Latched error flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the end-of-transfer double clear. The receive service flag must be cleared once while data is still draining. It must then be re-raised by the very pop that completes the programmed count, and only a second clear may remove it. The stimulus programs a target of three words and clears the flag before the pops start. It pops the words one at a time and checks the flag after each pop. Then it clears the service and done flags separately, so the bench can see that each clear acts on its own bit. Block wrap counting across a rejected push at a full FIFO is reached by mixing an illegal push into an otherwise regular push sequence.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

  // words per block for a 2-bit block code: 0 -> 1 word, n -> 4*n words
  function automatic int unsigned blk_words(input logic [1:0] code);
    return (code == 2'd0) ? 1 : 4 * int'(code);
  endfunction

  // FIFO depth in words: block times (2 << depth code)
  function automatic int unsigned fifo_words(input logic [1:0] bcode,
                                             input logic [2:0] dcode);
    return blk_words(bcode) * (2 << dcode);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    A_STATUS = 3'd0,
    A_ERR    = 3'd1,
    A_ERR_EN = 3'd2,
    A_MASK   = 3'd3,
    A_RX_CNT = 3'd4,
    A_TX_CNT = 3'd5
  } fsf_addr_e;

  // status bit positions (software decodes these)
  localparam int ST_RX_BLK  = 13;
  localparam int ST_TX_BLK  = 12;
  localparam int ST_RX_DONE = 11;
  localparam int ST_TX_DONE = 10;
  localparam int ST_RX_SVC  = 9;
  localparam int ST_TX_SVC  = 8;

endpackage

// File: rtl/fsf_dir_track.sv
module fsf_dir_track #(
  parameter int BLK   = 4,
  parameter int DEPTH = 8,
  parameter int LVL_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             fill,
  input  logic             drain,
  input  logic [LVL_W-1:0] level,
  input  logic [CNT_W-1:0] target,
  output logic             fill_wrap,
  output logic             drain_wrap,
  output logic             done_evt,
  output logic             over_evt,
  output logic             under_evt,
  output logic             have_block,
  output logic             room_block,
  output logic             full,
  output logic             nonempty
);
  localparam int BCW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam logic [BCW-1:0] BLK_LAST = BCW'(BLK - 1);

  logic [BCW-1:0]   fill_cnt, drain_cnt;
  logic [CNT_W-1:0] word_cnt;
  logic             fill_ok, drain_ok;

  assign full       = (level == LVL_W'(DEPTH));
  assign nonempty   = (level != '0);
  assign have_block = (level >= LVL_W'(BLK));
  assign room_block = ({1'b0, level} + (LVL_W+1)'(BLK)) <= (LVL_W+1)'(DEPTH);

  assign fill_ok   = fill && !full;
  assign drain_ok  = drain && nonempty;
  assign over_evt  = fill && full;
  assign under_evt = drain && !nonempty;

  assign fill_wrap  = fill_ok && (fill_cnt == BLK_LAST);
  assign drain_wrap = drain_ok && (drain_cnt == BLK_LAST);
  assign done_evt   = drain_ok && (target != '0) && ((word_cnt + 1'b1) == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      drain_cnt <= '0;
      word_cnt  <= '0;
    end else if (restart) begin
      fill_cnt  <= '0;
      drain_cnt <= '0;
      word_cnt  <= '0;
    end else begin
      if (fill_ok)  fill_cnt  <= fill_wrap  ? '0 : fill_cnt + 1'b1;
      if (drain_ok) drain_cnt <= drain_wrap ? '0 : drain_cnt + 1'b1;
      if (drain_ok) word_cnt  <= word_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsf_sticky.sv
module fsf_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fsf_service_flags.sv
module fsf_service_flags
  import fsf_pkg::*;
#(
  parameter logic [9:0] IO_SIZES = 10'h028,
  parameter int CNT_W = 16,
  localparam int RX_BLK   = blk_words(IO_SIZES[6:5]),
  localparam int RX_DEPTH = fifo_words(IO_SIZES[6:5], IO_SIZES[9:7]),
  localparam int TX_BLK   = blk_words(IO_SIZES[1:0]),
  localparam int TX_DEPTH = fifo_words(IO_SIZES[1:0], IO_SIZES[4:2]),
  localparam int LVL_W    = $clog2(max2(RX_DEPTH, TX_DEPTH) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [13:0]      op_status,
  output logic [5:0]       err_flags,
  output logic             irq
);
  // decoded writes
  logic wr_status, wr_err, wr_err_en, wr_mask, wr_rx_cnt, wr_tx_cnt;
  assign wr_status = reg_wr && (reg_addr == A_STATUS);
  assign wr_err    = reg_wr && (reg_addr == A_ERR);
  assign wr_err_en = reg_wr && (reg_addr == A_ERR_EN);
  assign wr_mask   = reg_wr && (reg_addr == A_MASK);
  assign wr_rx_cnt = reg_wr && (reg_addr == A_RX_CNT);
  assign wr_tx_cnt = reg_wr && (reg_addr == A_TX_CNT);

  logic [CNT_W-1:0] rx_target, tx_target;
  logic [5:2]       err_en;
  logic [9:8]       op_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_target <= '0;
      tx_target <= '0;
      err_en    <= '0;
      op_mask   <= '0;
    end else begin
      if (wr_rx_cnt) rx_target <= reg_wdata;
      if (wr_tx_cnt) tx_target <= reg_wdata;
      if (wr_err_en) err_en    <= reg_wdata[5:2];
      if (wr_mask)   op_mask   <= reg_wdata[9:8];
    end
  end

  // per-direction tracking; named event wires are also used by the checker
  logic rx_fill_wrap, rx_drain_wrap, rx_done_evt, rx_over_evt, rx_under_evt;
  logic rx_have_blk, rx_room_blk, rx_full, rx_nonempty;
  logic tx_fill_wrap, tx_drain_wrap, tx_done_evt, tx_over_evt, tx_under_evt;
  logic tx_have_blk, tx_room_blk, tx_full, tx_nonempty;

  fsf_dir_track #(.BLK(RX_BLK), .DEPTH(RX_DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) rx_trk_i (
    .clk(clk), .rst_n(rst_n), .restart(wr_rx_cnt),
    .fill(rx_push), .drain(rx_pop), .level(rx_level), .target(rx_target),
    .fill_wrap(rx_fill_wrap), .drain_wrap(rx_drain_wrap), .done_evt(rx_done_evt),
    .over_evt(rx_over_evt), .under_evt(rx_under_evt), .have_block(rx_have_blk),
    .room_block(rx_room_blk), .full(rx_full), .nonempty(rx_nonempty));

  fsf_dir_track #(.BLK(TX_BLK), .DEPTH(TX_DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) tx_trk_i (
    .clk(clk), .rst_n(rst_n), .restart(wr_tx_cnt),
    .fill(tx_push), .drain(tx_pop), .level(tx_level), .target(tx_target),
    .fill_wrap(tx_fill_wrap), .drain_wrap(tx_drain_wrap), .done_evt(tx_done_evt),
    .over_evt(tx_over_evt), .under_evt(tx_under_evt), .have_block(tx_have_blk),
    .room_block(tx_room_blk), .full(tx_full), .nonempty(tx_nonempty));

  // receive service: a block arrived, or the last counted word left (sticky end)
  logic rx_svc_set, tx_svc_set;
  assign rx_svc_set = rx_fill_wrap || rx_done_evt;
  assign tx_svc_set = tx_drain_wrap;

  // sticky status: [3]=rx done, [2]=tx done, [1]=rx service, [0]=tx service
  logic [3:0] st_set, st_clr, st_q;
  assign st_set = {rx_done_evt, tx_done_evt, rx_svc_set, tx_svc_set};
  assign st_clr = (wr_status ? reg_wdata[11:8] : 4'b0)
                | {wr_rx_cnt, wr_tx_cnt, 2'b00};

  fsf_sticky #(.N(4)) st_i (.clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr), .q(st_q));

  // errors: [5] tx overrun, [4] rx underrun, [3] tx underrun, [2] rx overrun
  logic [5:2] er_evt, er_q;
  assign er_evt = {tx_over_evt, rx_under_evt, tx_under_evt, rx_over_evt};

  fsf_sticky #(.N(4)) er_i (
    .clk(clk), .rst_n(rst_n),
    .set(er_evt & err_en),
    .clr(wr_err ? reg_wdata[5:2] : 4'b0),
    .q(er_q));

  assign op_status = {rx_have_blk, tx_room_blk, st_q,
                      rx_full, tx_full, rx_nonempty, tx_nonempty, 4'b0000};
  assign err_flags = {er_q, 2'b00};

  assign irq = (|er_q) || st_q[3] || st_q[2]
             || (st_q[1] && !op_mask[9]) || (st_q[0] && !op_mask[8]);
endmodule

// File: rtl/fsf_service_chk.sv
module fsf_service_chk #(
  parameter int LVL_W    = 4,
  parameter int CNT_W    = 16,
  parameter int RX_DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_push,
  input logic             rx_pop,
  input logic [LVL_W-1:0] rx_level,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [13:0]      op_status,
  input logic [5:0]       err_flags,
  input logic             irq,
  input logic             rx_fill_wrap,
  input logic             rx_svc_set,
  input logic [5:2]       err_en,
  input logic [9:8]       op_mask,
  input logic [CNT_W-1:0] rx_target
);
  p_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !op_status[5]);

  p_blk_svc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fill_wrap |=> op_status[9]);

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[9] && !rx_svc_set) |=> !op_status[9]);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_status[9] && !(reg_wr && reg_addr == 3'd0 && reg_wdata[9])) |=> op_status[9]);

  p_zero_tgt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_target == '0 && !op_status[11]) |=> !op_status[11]);

  p_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == LVL_W'(RX_DEPTH) && err_en[2]) |=> err_flags[2]);

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_status[9] && !op_mask[9]) |-> irq);

  p_err_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0) |-> irq);
endmodule

bind fsf_service_flags fsf_service_chk #(
  .LVL_W(LVL_W), .CNT_W(CNT_W), .RX_DEPTH(RX_DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_level(rx_level), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .op_status(op_status), .err_flags(err_flags),
  .irq(irq), .rx_fill_wrap(rx_fill_wrap), .rx_svc_set(rx_svc_set),
  .err_en(err_en), .op_mask(op_mask), .rx_target(rx_target));

// File: tb/fsf_service_flags_tb_top.sv
`timescale 1ns/1ps
module fsf_service_flags_tb_top;
  localparam int LW = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [LW-1:0] rx_level = 0, tx_level = 0;
  logic          reg_wr = 0;
  logic [2:0]    reg_addr = 0;
  logic [CW-1:0] reg_wdata = 0;
  logic [13:0]   op_status;
  logic [5:0]    err_flags;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fsf_service_flags #(.IO_SIZES(10'h028), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
    .rx_level(rx_level), .tx_push(tx_push), .tx_pop(tx_pop),
    .tx_level(tx_level), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .op_status(op_status), .err_flags(err_flags),
    .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regw(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rxpush(input int lv);
    @(negedge clk); rx_push = 1; rx_level = LW'(lv);
    @(negedge clk); rx_push = 0;
  endtask

  task automatic rxpop(input int lv);
    @(negedge clk); rx_pop = 1; rx_level = LW'(lv);
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic txpop(input int lv);
    @(negedge clk); tx_pop = 1; tx_level = LW'(lv);
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic clear_all();
    regw(3'd0, 16'h0F00);
    regw(3'd1, 16'h003C);
    rx_level = 0; tx_level = 0;
  endtask

  task automatic t_reset();
    chk("R11 status after reset", 32'(op_status), 32'h1000);
    chk("R11 errors after reset", 32'(err_flags), 0);
    chk("R11 irq after reset", 32'(irq), 0);
  endtask

  task automatic t_levels();
    @(negedge clk); rx_level = 3; #1;
    chk("R1 rx block req below 4", 32'(op_status[13]), 0);
    chk("R2 rx not empty", 32'(op_status[5]), 1);
    rx_level = 4; #1;
    chk("R1 rx block req at 4", 32'(op_status[13]), 1);
    rx_level = 8; #1;
    chk("R1 rx full at 8", 32'(op_status[7]), 1);
    tx_level = 7; #1;
    chk("R1 tx room at 7", 32'(op_status[12]), 1);
    chk("R2 tx flags at 7", 32'({op_status[6], op_status[4]}), 32'b01);
    tx_level = 8; #1;
    chk("R2 tx no room full at 8", 32'({op_status[12], op_status[6]}), 32'b01);
    chk("R2 low bits zero", 32'(op_status[3:0]), 0);
    rx_level = 0; tx_level = 0;
  endtask

  task automatic t_rx_service();
    regw(3'd4, 16'd0);
    for (int i = 0; i < 3; i++) rxpush(i);
    chk("R3 no service after 3 pushes", 32'(op_status[9]), 0);
    rxpush(8);
    chk("R3 full push not counted", 32'(op_status[9]), 0);
    chk("R9 disabled error not latched", 32'(err_flags), 0);
    rxpush(3);
    chk("R3 service after 4th accepted push", 32'(op_status[9]), 1);
    regw(3'd0, 16'h0200);
    chk("R5 rx service cleared", 32'(op_status[9]), 0);
  endtask

  task automatic t_tx_service();
    txpop(5);
    chk("R4 tx service after one-word block", 32'(op_status[8]), 1);
    regw(3'd0, 16'h0000);
    chk("R5 zero write keeps flag", 32'(op_status[8]), 1);
    @(negedge clk); tx_pop = 1; tx_level = 4; reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0100;
    @(negedge clk); tx_pop = 0; reg_wr = 0;
    chk("R5 set wins over clear", 32'(op_status[8]), 1);
    regw(3'd0, 16'h0100);
    txpop(0);
    chk("R4 empty pop not counted", 32'(op_status[8]), 0);
  endtask

  task automatic t_rx_done();
    regw(3'd4, 16'd3);
    regw(3'd0, 16'h0F00);
    rxpop(3); rxpop(2);
    chk("R6 not done after 2 pops", 32'(op_status[11]), 0);
    chk("R8 service clear before end", 32'(op_status[9]), 0);
    rxpop(1);
    chk("R6 done at target", 32'(op_status[11]), 1);
    chk("R8 service re-raised at end", 32'(op_status[9]), 1);
    regw(3'd0, 16'h0200);
    chk("R8 second clear of service", 32'({op_status[11], op_status[9]}), 32'b10);
    regw(3'd0, 16'h0800);
    chk("R6 done cleared", 32'(op_status[11]), 0);
    regw(3'd4, 16'd0);
    for (int i = 0; i < 5; i++) rxpop(5);
    chk("R6 zero target never done", 32'(op_status[11]), 0);
    regw(3'd4, 16'd1);
    rxpop(2);
    regw(3'd4, 16'd2);
    chk("R6 count write clears done", 32'(op_status[11]), 0);
  endtask

  task automatic t_tx_done();
    regw(3'd5, 16'd2);
    txpop(4);
    chk("R7 not done after 1 pop", 32'(op_status[10]), 0);
    txpop(3);
    chk("R7 done after 2 pops", 32'(op_status[10]), 1);
  endtask

  task automatic t_errors();
    clear_all();
    regw(3'd2, 16'h003C);
    rxpush(8);
    chk("R9 rx overrun bit2", 32'(err_flags), 32'h04);
    rxpop(0);
    @(negedge clk); tx_push = 1; tx_level = 8;
    @(negedge clk); tx_push = 0;
    txpop(0);
    chk("R9 all four errors", 32'(err_flags), 32'h3C);
    regw(3'd1, 16'h0004);
    chk("R9 w1c on error bit2", 32'(err_flags), 32'h38);
    clear_all();
    chk("R9 errors cleared", 32'(err_flags), 0);
  endtask

  task automatic t_irq();
    clear_all();
    regw(3'd4, 16'd0); regw(3'd5, 16'd0);
    chk("R10 irq idle", 32'(irq), 0);
    txpop(5);
    chk("R10 irq from tx service", 32'(irq), 1);
    regw(3'd3, 16'h0100);
    chk("R10 masked service no irq", 32'(irq), 0);
    chk("R10 status still visible", 32'(op_status[8]), 1);
    for (int i = 0; i < 4; i++) rxpush(i);
    chk("R10 unmasked rx service irq", 32'(irq), 1);
    regw(3'd3, 16'h0300);
    chk("R10 both masked", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_rx_service();
    t_tx_service();
    t_rx_done();
    t_tx_done();
    t_errors();
    t_irq();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule